// File: doc/BRIEF.md
# Infrared SIR Encoder/Decoder

This block sits between a UART's serial bit streams and an infrared transceiver. It converts the UART transmit stream into the pulse code used on a serial infrared link, and converts received light pulses back into a UART receive stream. On the transmit side, every zero bit becomes one short active-low pulse on `sir_out_n`. A one bit leaves the output high. On the receive side, each qualified pulse on `sir_in` drives `uart_rx` low for one full bit period. The link is half-duplex at rates up to 115200 bps. While the encoder is sending, the receive path is held idle so that the local optical echo is not received.

Bit timing comes from `baud16_tick`, a one-clock strobe at sixteen times the bit rate. In normal mode a pulse lasts 3 of the 16 ticks of a bit. In low-power mode the pulse lasts 3 periods of `lp_tick`, a separate reference strobe at about 1.8432 MHz. That gives a width of about 1.63 µs whatever the bit rate. When `sir_en` is low the block is transparent: the UART talks to the plain pins `pad_txd` and `pad_rxd`, and the infrared path is parked.

Encoder states: `ENC_IDLE` (line idle), `ENC_PULSE` (pulse driven), `ENC_ZERO_TAIL` (rest of a zero bit), `ENC_ONE_BIT` (a one bit being timed). Transitions:
- `ENC_IDLE` to `ENC_PULSE` when a tick sees `uart_tx` low.
- `ENC_PULSE` to `ENC_ZERO_TAIL` when the width expires.
- At each bit boundary (the 16th tick), `ENC_PULSE`, `ENC_ZERO_TAIL` or `ENC_ONE_BIT` go to `ENC_PULSE` if `uart_tx` is low. Otherwise they go to `ENC_ONE_BIT`, or to `ENC_IDLE` when the ending bit was already a one bit.
- Any state goes to `ENC_IDLE` when `sir_en` is low.

Decoder states: `DEC_IDLE`, `DEC_QUAL` (rising edge seen, waiting for a second high sample), `DEC_HOLD` (receive output low). Transitions:
- `DEC_IDLE` to `DEC_QUAL` on a rising edge of the synchronized input.
- `DEC_QUAL` to `DEC_HOLD` if the input is still high, otherwise back to `DEC_IDLE`.
- `DEC_HOLD` to `DEC_IDLE` on the 16th tick.
- Any state goes to `DEC_IDLE` when the decoder is disabled.

Top module: `sir_endec`

## Requirements
- R1: With `sir_en` low, `pad_txd` equals `uart_tx`, `uart_rx` equals `pad_rxd`, and `sir_out_n` is high.
- R2: With `sir_en` high, `pad_txd` is held high.
- R3: With `sir_en` high, a `baud16_tick` at a bit boundary (or from idle) that finds `uart_tx` low makes `sir_out_n` go low from the next clock.
- R4: In normal mode (`low_power` = 0) each pulse lasts exactly 3 `baud16_tick` periods.
- R5: In low-power mode (`low_power` = 1) each pulse lasts 3 `lp_tick` periods.
- R6: Bit slots are 16 ticks long. A one bit produces no pulse, and each zero bit of a frame produces exactly one pulse.
- R7: A rising edge on `sir_in` that stays high for at least two clocks drives `uart_rx` low after a 2-stage synchronizer and qualification. It stays low for 16 `baud16_tick` periods.
- R8: An `sir_in` pulse one clock long is ignored, and `uart_rx` stays high.
- R9: From the first zero bit sent until a full one-bit period with `uart_tx` high has elapsed, `uart_rx` is held high and received pulses are discarded.
- R10: Clearing `sir_en` returns both encoder and decoder to idle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sir_en | input | 1 | 1 selects the infrared path, 0 the plain UART pins |
| low_power | input | 1 | 1 selects the fixed low-power pulse width |
| baud16_tick | input | 1 | One-clock strobe at 16x the bit rate |
| lp_tick | input | 1 | One-clock low-power reference strobe |
| uart_tx | input | 1 | Serial transmit stream from the UART, idle high |
| uart_rx | output | 1 | Serial receive stream to the UART, idle high |
| pad_txd | output | 1 | Plain UART transmit pin |
| pad_rxd | input | 1 | Plain UART receive pin |
| sir_out_n | output | 1 | Active-low infrared transmit pulse |
| sir_in | input | 1 | Infrared receive pulse, active high |

## Verification
The bench runs a frame that mixes isolated and back-to-back zero bits. A wrong bit-slot counter would drop or double pulses, or shift them by a tick. An off-by-one width counter would stretch the 12-cycle normal pulse, or let the low-power pulse follow the bit rate. On the receive side, a one-clock glitch must not reach `uart_rx`, and a qualified pulse must hold the line low for sixteen ticks. A pulse arriving during transmission must stay invisible, or the UART would read its own echo. Dropping `sir_en` in the middle of a pulse must release the pin at once and leave no stale state behind.

// File: rtl/sir_pkg.sv
package sir_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE,
        ENC_PULSE,
        ENC_ZERO_TAIL,
        ENC_ONE_BIT
    } enc_state_e;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_QUAL,
        DEC_HOLD
    } dec_state_e;

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sir_encoder.sv
module sir_encoder
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int LP_TICKS      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic low_power,
    input  logic baud16_tick,
    input  logic lp_tick,
    input  logic tx_bit,
    output logic pulse_n,
    output logic busy
);
    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam int LW = $clog2(LP_TICKS + 1);
    localparam logic [TW-1:0] LAST_TICK  = TW'(TICKS_PER_BIT - 1);
    localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_TICKS - 1);
    localparam logic [LW-1:0] LP_LAST    = LW'(LP_TICKS - 1);

    enc_state_e      state, state_nxt;
    logic [TW-1:0]   tcnt, tcnt_nxt;
    logic [LW-1:0]   lcnt, lcnt_nxt;
    logic            slot_end;

    assign slot_end = baud16_tick && (tcnt == LAST_TICK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ENC_IDLE;
            tcnt  <= '0;
            lcnt  <= '0;
        end else begin
            state <= state_nxt;
            tcnt  <= tcnt_nxt;
            lcnt  <= lcnt_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        tcnt_nxt  = tcnt;
        lcnt_nxt  = lcnt;
        if (!enable) begin
            state_nxt = ENC_IDLE;
            tcnt_nxt  = '0;
            lcnt_nxt  = '0;
        end else begin
            unique case (state)
                ENC_IDLE: begin
                    if (baud16_tick && !tx_bit) begin
                        state_nxt = ENC_PULSE;
                        tcnt_nxt  = '0;
                        lcnt_nxt  = '0;
                    end
                end
                ENC_PULSE: begin
                    if (slot_end) begin
                        tcnt_nxt  = '0;
                        lcnt_nxt  = '0;
                        state_nxt = tx_bit ? ENC_ONE_BIT : ENC_PULSE;
                    end else begin
                        if (baud16_tick) tcnt_nxt = tcnt + 1'b1;
                        if (low_power) begin
                            if (lp_tick) begin
                                if (lcnt == LP_LAST) state_nxt = ENC_ZERO_TAIL;
                                else                 lcnt_nxt  = lcnt + 1'b1;
                            end
                        end else if (baud16_tick && tcnt == PULSE_LAST) begin
                            state_nxt = ENC_ZERO_TAIL;
                        end
                    end
                end
                ENC_ZERO_TAIL: begin
                    if (slot_end) begin
                        tcnt_nxt  = '0;
                        lcnt_nxt  = '0;
                        state_nxt = tx_bit ? ENC_ONE_BIT : ENC_PULSE;
                    end else if (baud16_tick) begin
                        tcnt_nxt = tcnt + 1'b1;
                    end
                end
                ENC_ONE_BIT: begin
                    if (slot_end) begin
                        tcnt_nxt  = '0;
                        lcnt_nxt  = '0;
                        state_nxt = tx_bit ? ENC_IDLE : ENC_PULSE;
                    end else if (baud16_tick) begin
                        tcnt_nxt = tcnt + 1'b1;
                    end
                end
                default: state_nxt = ENC_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_n = (state != ENC_PULSE);
        busy    = (state != ENC_IDLE);
    end
endmodule

// File: rtl/sir_decoder.sv
module sir_decoder
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic baud16_tick,
    input  logic pulse_in,
    output logic rx_out
);
    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);

    dec_state_e    state, state_nxt;
    logic [TW-1:0] tcnt, tcnt_nxt;
    logic          prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DEC_IDLE;
            tcnt  <= '0;
            prev  <= 1'b0;
        end else begin
            state <= state_nxt;
            tcnt  <= tcnt_nxt;
            prev  <= pulse_in;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        tcnt_nxt  = tcnt;
        if (!enable) begin
            state_nxt = DEC_IDLE;
            tcnt_nxt  = '0;
        end else begin
            unique case (state)
                DEC_IDLE: begin
                    if (pulse_in && !prev) state_nxt = DEC_QUAL;
                end
                DEC_QUAL: begin
                    if (pulse_in) begin
                        state_nxt = DEC_HOLD;
                        tcnt_nxt  = '0;
                    end else begin
                        state_nxt = DEC_IDLE;
                    end
                end
                DEC_HOLD: begin
                    if (baud16_tick) begin
                        if (tcnt == LAST_TICK) state_nxt = DEC_IDLE;
                        else                   tcnt_nxt  = tcnt + 1'b1;
                    end
                end
                default: state_nxt = DEC_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rx_out = (state != DEC_HOLD);
    end
endmodule

// File: rtl/sir_endec.sv
module sir_endec #(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int LP_TICKS      = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sir_en,
    input  logic low_power,
    input  logic baud16_tick,
    input  logic lp_tick,
    input  logic uart_tx,
    output logic uart_rx,
    output logic pad_txd,
    input  logic pad_rxd,
    output logic sir_out_n,
    input  logic sir_in
);
    logic enc_pulse_n;
    logic enc_busy;
    logic sync_in;
    logic dec_rx;
    logic dec_en;

    sir_encoder #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .PULSE_TICKS   (PULSE_TICKS),
        .LP_TICKS      (LP_TICKS)
    ) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (sir_en),
        .low_power   (low_power),
        .baud16_tick (baud16_tick),
        .lp_tick     (lp_tick),
        .tx_bit      (uart_tx),
        .pulse_n     (enc_pulse_n),
        .busy        (enc_busy)
    );

    sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sir_in),
        .q     (sync_in)
    );

    assign dec_en = sir_en && !enc_busy;

    sir_decoder #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (dec_en),
        .baud16_tick (baud16_tick),
        .pulse_in    (sync_in),
        .rx_out      (dec_rx)
    );

    always_comb begin
        sir_out_n = enc_pulse_n | ~sir_en;
        pad_txd   = sir_en ? 1'b1 : uart_tx;
        uart_rx   = sir_en ? (dec_rx | enc_busy) : pad_rxd;
    end
endmodule

// File: rtl/sir_endec_chk.sv
module sir_endec_chk (
    input logic clk,
    input logic rst_n,
    input logic sir_en,
    input logic low_power,
    input logic baud16_tick,
    input logic uart_tx,
    input logic sir_out_n,
    input logic enc_busy,
    input logic dec_rx,
    input logic sync_in
);
    assert_pulse_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sir_out_n) |-> $past(baud16_tick && !uart_tx && sir_en));

    assert_normal_width_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sir_out_n) && sir_en && $past(sir_en) && $past(!low_power)) |-> $past(baud16_tick));

    assert_glitch_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_rx) |-> ($past(sync_in, 1) && $past(sync_in, 2)));

    assert_echo_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enc_busy) |-> dec_rx);

    assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sir_en) |-> (!enc_busy && dec_rx));
endmodule

bind sir_endec sir_endec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sir_en      (sir_en),
    .low_power   (low_power),
    .baud16_tick (baud16_tick),
    .uart_tx     (uart_tx),
    .sir_out_n   (sir_out_n),
    .enc_busy    (enc_busy),
    .dec_rx      (dec_rx),
    .sync_in     (sync_in)
);

// File: tb/tb_sir_endec.sv
`timescale 1ns/1ps
module tb_sir_endec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sir_en = 1'b0, low_power = 1'b0;
    logic baud16_tick = 1'b0, lp_tick = 1'b0;
    logic uart_tx = 1'b1, pad_rxd = 1'b1, sir_in = 1'b0;
    logic uart_rx, pad_txd, sir_out_n;

    always #10 clk = ~clk;

    sir_endec dut (
        .clk(clk), .rst_n(rst_n), .sir_en(sir_en), .low_power(low_power),
        .baud16_tick(baud16_tick), .lp_tick(lp_tick), .uart_tx(uart_tx),
        .uart_rx(uart_rx), .pad_txd(pad_txd), .pad_rxd(pad_rxd),
        .sir_out_n(sir_out_n), .sir_in(sir_in)
    );

    // tick generators
    int cyc = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        baud16_tick <= (cyc % 4 == 0);
        lp_tick     <= (cyc % 5 == 0);
    end

    // behavioural reference: bit-slot timer and receive hold timer
    int m_mode = 0;   // 0 quiet, 1 emitting, 2 zero slot after pulse, 3 one slot
    int m_slot = 0, m_lp = 0;
    int m_q1 = 0, m_q2 = 0, m_last = 0;
    int m_rx = 0;     // 0 idle, 1 edge seen, 2 holding low
    int m_hold = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_slot = 0; m_lp = 0;
            m_q1 = 0; m_q2 = 0; m_last = 0; m_rx = 0; m_hold = 0;
        end else begin
            automatic int was_busy = (m_mode != 0);
            automatic int q2 = m_q2, last = m_last;
            if (!sir_en) begin
                m_mode = 0; m_slot = 0; m_lp = 0;
            end else if (m_mode == 0) begin
                if (baud16_tick && !uart_tx) begin m_mode = 1; m_slot = 0; m_lp = 0; end
            end else if (baud16_tick && m_slot == 15) begin
                if (!uart_tx) m_mode = 1;
                else m_mode = (m_mode == 3) ? 0 : 3;
                m_slot = 0; m_lp = 0;
            end else begin
                if (m_mode == 1) begin
                    if (low_power) begin
                        if (lp_tick) begin
                            if (m_lp == 2) m_mode = 2; else m_lp++;
                        end
                    end else if (baud16_tick && m_slot == 2) m_mode = 2;
                end
                if (baud16_tick) m_slot++;
            end
            m_last = q2; m_q2 = m_q1; m_q1 = sir_in;
            if (!sir_en || was_busy) begin
                m_rx = 0; m_hold = 0;
            end else if (m_rx == 0) begin
                if (q2 && !last) m_rx = 1;
            end else if (m_rx == 1) begin
                if (q2) begin m_rx = 2; m_hold = 0; end else m_rx = 0;
            end else if (baud16_tick) begin
                if (m_hold == 15) m_rx = 0; else m_hold++;
            end
        end
    end

    // per-cycle comparison and pulse-run monitor
    string phase = "R1";
    int cyc_checks = 0, cyc_errs = 0;
    int out_falls = 0, out_run = 0, out_len = 0;
    int rx_falls = 0, rx_run = 0, rx_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic e_out = !(sir_en && m_mode == 1);
            automatic logic e_pad = sir_en ? 1'b1 : uart_tx;
            automatic logic e_rx  = sir_en ? ((m_rx != 2) || (m_mode != 0)) : pad_rxd;
            cyc_checks += 3;
            if (sir_out_n !== e_out) begin
                cyc_errs++; $display("FAIL %s sir_out_n actual=%b expected=%b t=%0t", phase, sir_out_n, e_out, $time);
            end
            if (pad_txd !== e_pad) begin
                cyc_errs++; $display("FAIL %s pad_txd actual=%b expected=%b t=%0t", phase, pad_txd, e_pad, $time);
            end
            if (uart_rx !== e_rx) begin
                cyc_errs++; $display("FAIL %s uart_rx actual=%b expected=%b t=%0t", phase, uart_rx, e_rx, $time);
            end
            if (!sir_out_n) out_run++;
            else if (out_run != 0) begin out_falls++; out_len = out_run; out_run = 0; end
            if (sir_en && !uart_rx) rx_run++;
            else if (rx_run != 0) begin rx_falls++; rx_len = rx_run; rx_run = 0; end
        end
    end

    int checks = 0, errs = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [9:0] bits);
        for (int i = 0; i < 10; i++) begin
            uart_tx = bits[i];
            waitc(64);
        end
        uart_tx = 1'b1;
        waitc(200);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs + cyc_errs, checks + cyc_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        int f;
        waitc(3);
        chk(sir_out_n === 1'b1, "R1 reset sir_out_n", sir_out_n, 1);
        chk(uart_rx === pad_rxd, "R1 reset uart_rx", uart_rx, pad_rxd);
        rst_n = 1'b1;
        // R1 plain mode
        phase = "R1";
        uart_tx = 1'b0; pad_rxd = 1'b0; sir_in = 1'b1;
        waitc(1);
        chk(pad_txd === 1'b0, "R1 pad_txd follows", pad_txd, 0);
        chk(uart_rx === 1'b0, "R1 uart_rx follows", uart_rx, 0);
        chk(sir_out_n === 1'b1, "R1 sir_out_n quiet", sir_out_n, 1);
        waitc(40);
        uart_tx = 1'b1; pad_rxd = 1'b1; sir_in = 1'b0;
        waitc(20);
        // R2..R4, R6 normal mode frame
        sir_en = 1'b1; phase = "R4";
        waitc(1);
        chk(pad_txd === 1'b1, "R2 pad_txd idle", pad_txd, 1);
        f = out_falls;
        send_frame(10'b1110110010);
        chk(out_falls - f == 4, "R6 pulse count", out_falls - f, 4);
        chk(out_len == 12, "R4 pulse width", out_len, 12);
        f = out_falls;
        send_frame(10'b1111111110);
        chk(out_falls - f == 1, "R3 lone start pulse", out_falls - f, 1);
        // R5 low power
        low_power = 1'b1; phase = "R5";
        f = out_falls;
        send_frame(10'b1100100100);
        chk(out_falls - f == 6, "R5 pulse count", out_falls - f, 6);
        chk(out_len >= 11 && out_len <= 15, "R5 pulse width", out_len, 13);
        low_power = 1'b0;
        // R8 glitch
        phase = "R8";
        f = rx_falls;
        sir_in = 1'b1; waitc(1); sir_in = 1'b0;
        waitc(100);
        chk(rx_falls == f, "R8 glitch ignored", rx_falls - f, 0);
        // R7 qualified pulses
        phase = "R7";
        f = rx_falls;
        sir_in = 1'b1; waitc(3); sir_in = 1'b0;
        waitc(100);
        chk(rx_falls - f == 1, "R7 one low period", rx_falls - f, 1);
        chk(rx_len >= 61 && rx_len <= 64, "R7 hold length", rx_len, 64);
        f = rx_falls;
        for (int k = 0; k < 2; k++) begin
            sir_in = 1'b1; waitc(4); sir_in = 1'b0; waitc(70);
        end
        waitc(30);
        chk(rx_falls - f == 2, "R7 two pulses", rx_falls - f, 2);
        // R9 echo suppression
        phase = "R9";
        f = rx_falls;
        uart_tx = 1'b0;
        waitc(20);
        sir_in = 1'b1; waitc(4); sir_in = 1'b0;
        waitc(40);
        uart_tx = 1'b1;
        waitc(30);
        sir_in = 1'b1; waitc(4); sir_in = 1'b0;
        waitc(200);
        chk(rx_falls == f, "R9 echo hidden", rx_falls - f, 0);
        // R10 disable mid-pulse
        phase = "R10";
        uart_tx = 1'b0;
        while (sir_out_n) waitc(1);
        sir_en = 1'b0;
        waitc(1);
        chk(sir_out_n === 1'b1, "R10 pin released", sir_out_n, 1);
        chk(pad_txd === 1'b0, "R1 pad_txd after disable", pad_txd, 0);
        waitc(1);
        sir_en = 1'b1; uart_tx = 1'b1;
        waitc(100);
        chk(sir_out_n === 1'b1, "R10 restarts idle", sir_out_n, 1);
        waitc(10);
        finish_run();
    end
endmodule